// File: doc/BRIEF.md
# Quad DAC parallel write controller

This block is a bus master for a four-channel 8-bit converter that has a single shared data port. Each write request arrives over a valid/ready handshake and carries a 2-bit channel number and an 8-bit code. The controller turns the request into one write cycle on the converter's parallel interface: it drives the two channel-select lines and the 8-bit data bus, pulses an active-low write strobe, and then keeps address and data unchanged for a hold time after the strobe rises.

The converter's input latches are level sensitive. The selected channel follows the data bus for as long as the strobe is low, and it captures the data when the strobe rises. For this reason the controller never moves address or data while the strobe is low. Every timing interval is a parameter in nanoseconds. The controller converts each one into whole clock cycles, rounding up, at the configured clock period. A busy output reports that a write cycle is in progress.

Top module: `qdac_wr_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the strobe `dac_wr_n` is high, `dac_ch` and `dac_code` are 0, `req_ready` is 1 and `busy` is 0.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no write cycle is running. `busy` is high from the cycle after acceptance until the cycle in which the write cycle ends.
- R3: From the cycle after acceptance, `dac_ch` carries the request's channel number (00 selects the first channel, 01 the second, 10 the third, 11 the fourth) and `dac_code` carries its code.
- R4: The strobe stays high for the setup interval after address and data are driven. With the default parameters this is 1 cycle, and the strobe falls in the second busy cycle.
- R5: The strobe stays low for the larger of the pulse-width and data-setup intervals, each rounded up to cycles. The default is 20 cycles.
- R6: `dac_ch` and `dac_code` do not change while the strobe is low, or during the hold interval after it rises. The default hold is 1 cycle.
- R7: After the hold interval, `busy` falls and `req_ready` returns. A request that stays valid while the controller is busy is not taken until then, and changes to its payload during that time do not reach `dac_ch` or `dac_code`. Each accepted request produces exactly one strobe pulse.
- R8: Whenever the controller is idle, the strobe is high, whatever the channel lines show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_ch | input | 2 | Target channel of the request |
| req_code | input | 8 | Code to write |
| dac_ch | output | 2 | Channel-select lines to the converter |
| dac_code | output | 8 | Shared data bus to the converter |
| dac_wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Write cycle in progress |

## Verification
The bench sends single writes to each of the four channels, using all-zero, all-one and alternating-bit codes. These writes show whether the address decode and the data path drive the correct lines. It also holds `req_valid` high across consecutive transactions while the payload changes mid-cycle, which separates a controller that samples only at acceptance from one that lets the bus follow its input while the strobe is low. Idle gaps of different lengths, and a reset in the middle of a strobe pulse, show whether the strobe returns high and the idle state is entered cleanly.

// File: rtl/qdac_wr_pkg.sv
package qdac_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HOLD  = 2'd3
    } wr_state_e;

    // Round a nanosecond interval up to whole clock cycles, with a floor.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned per_ns,
                                              input int unsigned floor_cyc);
        int unsigned c;
        c = (ns + per_ns - 1) / per_ns;
        return (c < floor_cyc) ? floor_cyc : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qdac_interval_timer.sv
module qdac_interval_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5: the timer never wraps below zero
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/qdac_seq_fsm.sv
module qdac_seq_fsm
    import qdac_wr_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned LOW_CYC   = 20,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             idle,
    output logic             wr_n
);
    wr_state_e state_q, state_d;
    logic      wr_n_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SETUP;
            ST_SETUP: if (tmr_done)  state_d = ST_LOW;
            ST_LOW:   if (tmr_done)  state_d = ST_HOLD;
            ST_HOLD:  if (tmr_done)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_SETUP: tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_LOW:   tmr_val = CNT_W'(LOW_CYC - 1);
            ST_HOLD:  tmr_val = CNT_W'(HOLD_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign idle     = (state_q == ST_IDLE);
    assign accept   = idle && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_n_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            wr_n_q  <= (state_d != ST_LOW);
        end
    end

    assign wr_n = wr_n_q;

    // R8: the strobe is high whenever the sequencer is idle
    p_idle_strobe_high_r8: assert property (@(posedge clk) disable iff (rst)
        idle |-> wr_n);
    // R4: the strobe only falls straight after the setup phase
    p_fall_after_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> ($past(state_q) == ST_SETUP));
endmodule

// File: rtl/qdac_bus_hold.sv
module qdac_bus_hold #(
    parameter int unsigned CH_W   = 2,
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [CODE_W-1:0] in_code,
    output logic [CH_W-1:0]   out_ch,
    output logic [CODE_W-1:0] out_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_ch   <= '0;
            out_code <= '0;
        end else if (capture) begin
            out_ch   <= in_ch;
            out_code <= in_code;
        end
    end
endmodule

// File: rtl/qdac_wr_ctrl.sv
module qdac_wr_ctrl
    import qdac_wr_pkg::*;
#(
    parameter int unsigned CH_W          = 2,
    parameter int unsigned CODE_W        = 8,
    parameter int unsigned CLK_NS        = 10,
    parameter int unsigned ADDR_SETUP_NS = 0,
    parameter int unsigned ADDR_HOLD_NS  = 10,
    parameter int unsigned DATA_SETUP_NS = 100,
    parameter int unsigned DATA_HOLD_NS  = 10,
    parameter int unsigned PULSE_NS      = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [CODE_W-1:0] req_code,
    output logic [CH_W-1:0]   dac_ch,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_wr_n,
    output logic              busy
);
    localparam int unsigned SETUP_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_NS, 1);
    localparam int unsigned LOW_CYC   = umax(ns_to_cyc(PULSE_NS, CLK_NS, 1),
                                             ns_to_cyc(DATA_SETUP_NS, CLK_NS, 1));
    localparam int unsigned HOLD_CYC  = ns_to_cyc(umax(ADDR_HOLD_NS, DATA_HOLD_NS), CLK_NS, 1);
    localparam int unsigned MAX_CYC   = umax(umax(SETUP_CYC, LOW_CYC), HOLD_CYC);
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_done, accept, idle;
    logic [CNT_W-1:0] tmr_val;

    qdac_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    qdac_seq_fsm #(
        .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .tmr_done(tmr_done),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .idle(idle),
        .wr_n(dac_wr_n)
    );

    qdac_bus_hold #(.CH_W(CH_W), .CODE_W(CODE_W)) u_bus (
        .clk(clk), .rst(rst), .capture(accept), .in_ch(req_ch), .in_code(req_code),
        .out_ch(dac_ch), .out_code(dac_code)
    );

    assign req_ready = idle;
    assign busy      = !idle;

    // Checker state: length of the current strobe-low run.
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (!dac_wr_n)
            low_run <= low_run + 1'b1;
        else
            low_run <= '0;
    end

    // R5: each low pulse lasts exactly the derived pulse length
    always_ff @(posedge clk) begin
        if (!rst && dac_wr_n && low_run != '0)
            p_pulse_len_r5: assert (low_run == (CNT_W+1)'(LOW_CYC));
        if (!rst && !dac_wr_n)
            p_pulse_bound_r5: assert (low_run < (CNT_W+1)'(LOW_CYC));
    end

    // R6: address and data frozen during the low phase and the cycle after it
    p_bus_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !dac_wr_n |=> ($stable(dac_ch) && $stable(dac_code)));
    // R7: a request held while busy does not reach the bus
    p_no_take_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> ($stable(dac_ch) && $stable(dac_code)));
    // R2: ready never coexists with a low strobe
    p_ready_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> dac_wr_n);
endmodule

// File: tb/qdac_wr_ctrl_bench.sv
module qdac_wr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int S_CYC = 1;
    localparam int L_CYC = 20;
    localparam int H_CYC = 1;
    localparam int TOTAL = S_CYC + L_CYC + H_CYC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_ch = '0;
    logic [7:0] req_code = '0;
    logic       req_ready, dac_wr_n, busy;
    logic [1:0] dac_ch;
    logic [7:0] dac_code;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    bit started = 0;

    // Reference model state
    int         m_t = 0;
    logic [1:0] m_ch = '0;
    logic [7:0] m_code = '0;
    bit         m_rst = 1;
    int         n_accept = 0;
    int         n_falls = 0;
    logic       prev_wr_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_wr_ctrl u_qdac_wr_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ch(req_ch), .req_code(req_code), .dac_ch(dac_ch), .dac_code(dac_code),
        .dac_wr_n(dac_wr_n), .busy(busy)
    );

    always @(posedge clk) begin
        started = 1;
        m_rst = rst;
        if (rst) begin
            m_t = 0; m_ch = '0; m_code = '0;
        end else if (m_t == 0) begin
            if (req_valid) begin
                m_t = 1; m_ch = req_ch; m_code = req_code;
                n_accept++;
            end
        end else begin
            m_t = (m_t == TOTAL) ? 0 : m_t + 1;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            logic  e_wr_n;
            string tg;
            e_wr_n = !(m_t > S_CYC && m_t <= S_CYC + L_CYC);
            if (m_rst) tg = "R1";
            else if (m_t == 0) tg = "R8";
            else if (m_t <= S_CYC) tg = "R4";
            else tg = "R5";
            check(tg, "dac_wr_n", int'(dac_wr_n), int'(e_wr_n));
            tg = m_rst ? "R1" : ((m_t > S_CYC) ? "R6" : "R3");
            check(tg, "dac_ch", int'(dac_ch), int'(m_ch));
            check(tg, "dac_code", int'(dac_code), int'(m_code));
            tg = m_rst ? "R1" : "R2";
            check(tg, "req_ready", int'(req_ready), int'(m_t == 0));
            check(tg, "busy", int'(busy), int'(m_t != 0));
            if (prev_wr_n && !dac_wr_n) n_falls++;
            prev_wr_n = dac_wr_n;
        end
    end

    task automatic send(input logic [1:0] ch, input logic [7:0] code);
        logic was_ready;
        req_valid = 1'b1; req_ch = ch; req_code = code;
        forever begin
            was_ready = req_ready;
            @(negedge clk);
            if (was_ready) break;
            req_code = ~req_code;   // R7: payload churn while waiting
        end
        req_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        idle_cycles(4);
        rst = 1'b0;
        idle_cycles(3);
        // R3: one write per channel with distinct patterns
        send(2'b00, 8'h00); idle_cycles(TOTAL + 2);
        send(2'b01, 8'hFF); idle_cycles(TOTAL + 5);
        send(2'b10, 8'h55); idle_cycles(TOTAL + 1);
        send(2'b11, 8'hAA); idle_cycles(TOTAL + 3);
        // R7: back-to-back with valid held and payload changing while busy
        send(2'b01, 8'h3C);
        send(2'b10, 8'hC3);
        send(2'b11, 8'h81);
        idle_cycles(TOTAL + 2);
        // R7: one strobe pulse per accepted request
        check("R7", "strobe pulses vs accepts", n_falls, n_accept);
        // R1: reset during a low pulse
        send(2'b10, 8'h77);
        idle_cycles(8);
        rst = 1'b1;
        idle_cycles(2);
        rst = 1'b0;
        idle_cycles(2);
        send(2'b00, 8'h12); idle_cycles(TOTAL + 2);
        finish_run();
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end
endmodule